// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block holds eight programmable 32-bit counters for a coherent interconnect. Each counter watches one event line. Software picks that line with a 9-bit identifier. The upper four bits of the identifier name a source: a slave-side port, a master-side port, or the global interconnect source. The lower five bits pick an event code inside that source.

Each clock, every event input is a single-cycle pulse vector:
- each of the seven slave-side ports drives 32 lines;
- each of the six master-side ports drives 7 lines;
- the global source drives 16 lines.

The bank checks every identifier when software writes it. An identifier that is not legal never lets its counter count, and it raises a sticky flag for that counter.

Software reaches the bank through a simple register bus with valid/ready and a registered read response. Each counter has its own 64 KiB address window. When a counter wraps past its maximum value, it raises an overflow flag. Overflow flags whose counter has its interrupt enable set are combined into one interrupt line. There is no fixed cycle counter.

Top module: `evc_bank`

## Requirements
- R1: After reset, every counter reads back as follows: select 0, count 0, control 0, status 0. The interrupt output is low.
- R2: Counter n (0..7) occupies the window at byte address 0x10000*(n+1). Inside a window there are four registers:
  - 0x0 is event select.
  - 0x4 is count.
  - 0x8 is control: bit 0 enables counting, bit 1 enables the interrupt.
  - 0xC is status: bit 0 is overflow, bit 1 is invalid selection.

  A read of any other address returns 0.
- R3: An enabled counter with a legal selection adds one on each clock in which its selected event line is high. It ignores every other event line. The identifier maps to a line as follows, with src = id[8:5] and code = id[4:0]:
  - src 0..6 selects slave line src*32+code;
  - src 8..13 selects master line (src-8)*7+code;
  - src 15 selects global line code.
- R4: Some identifiers are invalid:
  - src 7 or 14;
  - a master code above 6;
  - a global code above 15;
  - any set bit above bit 8 of the written word.

  An invalid identifier stops its counter from counting and sets status bit 1. That flag stays set after a later legal selection.
- R5: A counter whose control bit 0 is clear holds its value while events arrive.
- R6: An increment from 0xFFFFFFFF gives 0 and sets status bit 0.
- R7: The interrupt output is high exactly when some counter has both status bit 0 and control bit 1 set.
- R8: A software write to a count register in the same cycle as an increment leaves the written value.
- R9: Writing 1 to a status bit clears it. An overflow in the same cycle as a clear of bit 0 leaves bit 0 set.
- R10: The ready output is always high. A read returns its data with response valid one cycle after it is accepted. A select read returns the low 9 bits of the last written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| slave_ev | input | 224 | Slave-port event lines, 32 per port |
| master_ev | input | 42 | Master-port event lines, 7 per port |
| global_ev | input | 16 | Global event lines |
| irq | output | 1 | Combined overflow interrupt |

## Verification
Assertions check the following on every cycle:
- a counter moves by at most one per clock;
- a counter holds when it is disabled or its selection is illegal;
- a wrap sets the overflow flag;
- a count write lands exactly;
- the overflow flag stays set until cleared;
- at most one counter window is written at a time;
- read responses follow reads.

Only the bench scenarios can show that the identifier decode is exact. The bench sweeps all 512 identifiers and checks both that the chosen line counts and that no other line does. The scenarios also cover flag stickiness across a legal rewrite, interrupt gating by the enable bit, and the same-cycle conflicts between a write and an increment.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = 32;
    localparam int ID_W       = 9;
    localparam int N_SLV      = 7;
    localparam int N_MST      = 6;
    localparam int SLV_CODES  = 32;
    localparam int MST_CODES  = 7;
    localparam int GLB_CODES  = 16;
    localparam int MST_BASE   = 8;
    localparam int GLB_SRC    = 15;
    localparam int SLV_LINES  = N_SLV * SLV_CODES;
    localparam int MST_LINES  = N_MST * MST_CODES;
    localparam int EV_TOTAL   = SLV_LINES + MST_LINES + GLB_CODES;
    localparam int IDX_W      = $clog2(EV_TOTAL);

    typedef enum logic [1:0] {
        OFF_SEL  = 2'd0,
        OFF_CNT  = 2'd1,
        OFF_CTRL = 2'd2,
        OFF_STAT = 2'd3
    } reg_off_e;

    typedef struct packed {
        logic [ID_W-1:0]  sel;
        logic             ok;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             ie;
        logic             ovf;
        logic             bad;
    } ctr_state_t;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rsp_state_t;
endpackage

// File: rtl/evc_sel_decode.sv
module evc_sel_decode
    import evc_pkg::*;
#(
    parameter int N_SLV_P = N_SLV,
    parameter int N_MST_P = N_MST
) (
    input  logic [DATA_W-1:0] word,
    output logic              ok,
    output logic [IDX_W-1:0]  idx
);
    localparam int SLV_END  = N_SLV_P;
    localparam int MST_END  = MST_BASE + N_MST_P;
    localparam int MST_OFS  = N_SLV_P * SLV_CODES;
    localparam int GLB_OFS  = MST_OFS + N_MST_P * MST_CODES;

    always_comb begin
        int src;
        int code;
        logic hi_zero;
        src     = 32'(word[8:5]);
        code    = 32'(word[4:0]);
        hi_zero = (word[DATA_W-1:ID_W] == '0);
        ok      = 1'b0;
        idx     = '0;
        if (src < SLV_END) begin
            ok  = (code < SLV_CODES);
            idx = IDX_W'(src * SLV_CODES + code);
        end else if (src >= MST_BASE && src < MST_END) begin
            ok  = (code < MST_CODES);
            idx = IDX_W'(MST_OFS + (src - MST_BASE) * MST_CODES + code);
        end else if (src == GLB_SRC) begin
            ok  = (code < GLB_CODES);
            idx = IDX_W'(GLB_OFS + code);
        end
        ok = ok && hi_zero;
        if (!ok) idx = '0;
    end

    always_comb begin
        if (ok) assert_idx_range_R3: assert (int'(idx) < EV_TOTAL);
    end
endmodule

// File: rtl/evc_counter.sv
module evc_counter
    import evc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EV_TOTAL-1:0] ev_all,
    input  logic                wr_en,
    input  reg_off_e            off,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_word,
    output logic                irq_req
);
    ctr_state_t q, d;
    logic dec_ok;
    logic [IDX_W-1:0] dec_idx;
    logic hit, wrap, wr_cnt;

    evc_sel_decode u_dec (
        .word (wdata),
        .ok   (dec_ok),
        .idx  (dec_idx)
    );

    always_comb begin
        d      = q;
        hit    = q.en && q.ok && ev_all[q.idx];
        wrap   = hit && (q.cnt == '1);
        wr_cnt = wr_en && (off == OFF_CNT);
        if (hit) d.cnt = q.cnt + CNT_W'(1);
        if (wr_en) begin
            unique case (off)
                OFF_SEL: begin
                    d.sel = wdata[ID_W-1:0];
                    d.ok  = dec_ok;
                    d.idx = dec_idx;
                    if (!dec_ok) d.bad = 1'b1;
                end
                OFF_CNT:  d.cnt = wdata[CNT_W-1:0];
                OFF_CTRL: begin
                    d.en = wdata[0];
                    d.ie = wdata[1];
                end
                OFF_STAT: begin
                    if (wdata[0]) d.ovf = 1'b0;
                    if (wdata[1]) d.bad = 1'b0;
                end
                default: ;
            endcase
        end
        if (wrap) d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (off)
            OFF_SEL:  rd_word = DATA_W'(q.sel);
            OFF_CNT:  rd_word = DATA_W'(q.cnt);
            OFF_CTRL: rd_word = DATA_W'({q.ie, q.en});
            OFF_STAT: rd_word = DATA_W'({q.bad, q.ovf});
            default:  rd_word = '0;
        endcase
    end

    assign irq_req = q.ovf && q.ie;

    assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && !wr_cnt) |=> $stable(q.cnt));
    assert_hold_invalid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ok && !wr_cnt) |=> $stable(q.cnt));
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cnt |=> (q.cnt == $past(q.cnt) || q.cnt == $past(q.cnt) + CNT_W'(1)));
    assert_wrap_sets_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_cnt) |=> (q.ovf && q.cnt == '0));
    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (q.cnt == $past(wdata[CNT_W-1:0])));
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && !(wr_en && off == OFF_STAT && wdata[0])) |=> q.ovf);
endmodule

// File: rtl/evc_regif.sv
module evc_regif
    import evc_pkg::*;
#(
    parameter int N_CNT  = 8,
    parameter int ADDR_W = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [DATA_W-1:0]             req_wdata,
    input  logic [N_CNT-1:0][DATA_W-1:0]  rd_words,
    output logic [N_CNT-1:0]              wr_vec,
    output reg_off_e                      off,
    output logic [DATA_W-1:0]             wdata,
    output logic                          rsp_valid,
    output logic [DATA_W-1:0]             rsp_rdata
);
    localparam int WIN_LSB = 16;
    localparam int WIN_W   = ADDR_W - WIN_LSB;
    localparam int CIDX_W  = (N_CNT > 1) ? $clog2(N_CNT) : 1;

    rsp_state_t q, d;
    logic [WIN_W-1:0] win;
    logic [CIDX_W-1:0] cidx;
    logic hit;

    assign win   = req_addr[ADDR_W-1:WIN_LSB];
    assign hit   = (win != '0) && (32'(win) <= N_CNT) &&
                   (req_addr[WIN_LSB-1:4] == '0) && (req_addr[1:0] == 2'b00);
    assign cidx  = CIDX_W'(32'(win) - 1);
    assign off   = reg_off_e'(req_addr[3:2]);
    assign wdata = req_wdata;

    for (genvar g = 0; g < N_CNT; g++) begin : g_wr
        assign wr_vec[g] = req_valid && req_write && hit && (32'(cidx) == g);
    end

    always_comb begin
        d.vld  = req_valid && !req_write;
        d.data = '0;
        if (req_valid && !req_write && hit) d.data = rd_words[cidx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_valid = q.vld;
    assign rsp_rdata = q.data;

    assert_onehot_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));
    assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: rtl/evc_bank.sv
module evc_bank
    import evc_pkg::*;
#(
    parameter int N_CNT  = 8,
    parameter int ADDR_W = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic [SLV_LINES-1:0] slave_ev,
    input  logic [MST_LINES-1:0] master_ev,
    input  logic [GLB_CODES-1:0] global_ev,
    output logic                 irq
);
    logic [EV_TOTAL-1:0]             ev_all;
    logic [N_CNT-1:0][DATA_W-1:0]    rd_words;
    logic [N_CNT-1:0]                wr_vec;
    logic [N_CNT-1:0]                irq_vec;
    reg_off_e                        off;
    logic [DATA_W-1:0]               wdata;

    assign ev_all    = {global_ev, master_ev, slave_ev};
    assign req_ready = 1'b1;
    assign irq       = |irq_vec;

    evc_regif #(.N_CNT(N_CNT), .ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_words  (rd_words),
        .wr_vec    (wr_vec),
        .off       (off),
        .wdata     (wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    for (genvar g = 0; g < N_CNT; g++) begin : g_ctr
        evc_counter u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_all  (ev_all),
            .wr_en   (wr_vec[g]),
            .off     (off),
            .wdata   (wdata),
            .rd_word (rd_words[g]),
            .irq_req (irq_vec[g])
        );
    end
endmodule

// File: tb/tb_evc_bank.sv
`timescale 1ns/1ps
module tb_evc_bank;
    localparam int NS = 7 * 32;
    localparam int NM = 6 * 7;
    localparam int NG = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid, irq;
    logic [31:0] rsp_rdata;
    logic [NS-1:0] sev = '0;
    logic [NM-1:0] mev = '0;
    logic [NG-1:0] gev = '0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evc_bank dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .slave_ev(sev),
        .master_ev(mev), .global_ev(gev), .irq(irq)
    );

    function automatic logic [19:0] ra(int k, int o);
        return 20'(32'h10000 * (k + 1) + o);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [19:0] a, logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(logic [19:0] a, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd1);
        v = rsp_rdata;
    endtask

    task automatic clear_ev();
        sev = '0; mev = '0; gev = '0;
    endtask

    // Sets only the line an identifier selects; returns legality.
    task automatic target(logic [8:0] id, output bit legal);
        int s, c;
        s = int'(id[8:5]); c = int'(id[4:0]);
        clear_ev();
        legal = 1'b0;
        if (s <= 6) begin sev[s*32+c] = 1'b1; legal = 1'b1; end
        else if (s >= 8 && s <= 13 && c <= 6) begin mev[(s-8)*7+c] = 1'b1; legal = 1'b1; end
        else if (s == 15 && c <= 15) begin gev[c] = 1'b1; legal = 1'b1; end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        bit legal;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R10 ready", 32'(req_ready), 1);
        for (int o = 0; o < 16; o += 4) begin
            rd(ra(3, o), v); chk("R1 reg", v, 0);
        end
        // R2 unmapped reads
        rd(20'h00004, v); chk("R2 below window", v, 0);
        rd(20'h90000, v); chk("R2 above window", v, 0);
        rd(ra(2, 16), v); chk("R2 past regs", v, 0);

        for (int k = 0; k < 8; k++) wr(ra(k, 8), 32'd1);
        rd(ra(5, 8), v); chk("R2 ctrl readback", v, 1);

        // R3/R4 sweep over all identifiers
        for (int id = 0; id < 512; id++) begin
            int k;
            int ex;
            k = id % 8;
            clear_ev();
            wr(ra(k, 12), 32'd3);
            wr(ra(k, 0), 32'(id));
            wr(ra(k, 4), 32'd0);
            target(9'(id), legal);
            if (legal) begin
                hold(3);
                sev = ~sev; mev = ~mev; gev = ~gev;
                hold(2);
            end else begin
                sev = '1; mev = '1; gev = '1;
                hold(3);
            end
            clear_ev();
            ex = legal ? 3 : 0;
            rd(ra(k, 4), v);
            if (v !== 32'(ex)) $display("  id %0h", id);
            chk(legal ? "R3 count" : "R4 no count", v, 32'(ex));
            rd(ra(k, 12), v);
            chk("R4 invalid flag", v, legal ? 32'd0 : 32'd2);
        end

        // R4 upper bit makes id invalid, flag sticks after legal rewrite
        wr(ra(0, 12), 32'd3);
        wr(ra(0, 0), 32'h201);
        wr(ra(0, 4), 32'd0);
        sev = '1; hold(4); clear_ev();
        rd(ra(0, 4), v); chk("R4 upper bit no count", v, 0);
        rd(ra(0, 0), v); chk("R10 sel low 9 bits", v, 32'h001);
        wr(ra(0, 0), 32'h001);
        sev[1] = 1'b1; hold(4); clear_ev();
        rd(ra(0, 4), v); chk("R3 after legal rewrite", v, 4);
        rd(ra(0, 12), v); chk("R4 flag sticky", v, 2);
        wr(ra(0, 12), 32'd2);
        rd(ra(0, 12), v); chk("R9 clear invalid", v, 0);

        // R8 write wins over increment
        wr(ra(1, 0), 32'h000);
        sev[0] = 1'b1;
        wr(ra(1, 4), 32'd100);
        clear_ev();
        rd(ra(1, 4), v); chk("R8 write wins", v, 100);
        // R5 disabled hold
        wr(ra(1, 8), 32'd0);
        sev[0] = 1'b1; hold(5); clear_ev();
        rd(ra(1, 4), v); chk("R5 disabled hold", v, 100);

        // R6 wrap and R7 gating
        wr(ra(3, 0), 32'h1E2);
        wr(ra(3, 4), 32'hFFFF_FFFE);
        wr(ra(3, 12), 32'd3);
        wr(ra(3, 8), 32'd1);
        gev[2] = 1'b1; hold(2); clear_ev();
        rd(ra(3, 4), v); chk("R6 wrap to zero", v, 0);
        rd(ra(3, 12), v); chk("R6 overflow flag", v, 1);
        chk("R7 irq masked", 32'(irq), 0);
        wr(ra(3, 8), 32'd3);
        chk("R7 irq raised", 32'(irq), 1);
        wr(ra(3, 12), 32'd1);
        chk("R7 irq after clear", 32'(irq), 0);
        rd(ra(3, 12), v); chk("R9 clear overflow", v, 0);

        // R9 overflow in the same cycle as a clear
        wr(ra(3, 4), 32'hFFFF_FFFF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = ra(3, 12); req_wdata = 32'd1;
        gev[2] = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; clear_ev();
        rd(ra(3, 12), v); chk("R9 set wins", v, 1);
        chk("R7 irq set", 32'(irq), 1);
        wr(ra(3, 12), 32'd1);
        chk("R7 irq cleared", 32'(irq), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule